// File: doc/BRIEF.md
# Coherent Private Cache Controller with Snooping (MSI)

This block is the cache controller that sits beside one processor in a shared-bus multiprocessor. It holds a small direct-mapped cache of four lines, each line holding two data words, a coherence state (Invalid, Shared or Modified) and a tag that stores the whole block address. On the processor side it takes read and write requests one at a time. It raises a busy flag while it works and ends each request with a one-cycle completion pulse. That pulse carries the read word and the number of stall cycles the access cost.

On the bus side it issues four kinds of transaction: a shared read, an exclusive read, an invalidate and a block writeback. It holds each one until the bus acknowledges it. It also watches the transactions of the other caches. When another agent wants a block that this cache holds Modified, the controller drives the block out in the same cycle, reports the writeback cost charged to this cache, and downgrades or invalidates its copy. Stall costs come from four parameters: a fill from memory, a fill supplied by another cache, an invalidating write hit, and a writeback. A miss that must first evict a dirty victim pays the writeback cost plus the fill cost.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, and cpu_busy, cpu_done, bus_req and snp_flush are all 0.
- R2: For word address A, the line index is A[2:1], the word select is A[0] (word 0 sits in bits [DW-1:0] of a block) and the stored tag is the block address A[AW-1:1]. A read hit (state not Invalid, tag equal) raises cpu_done in the cycle after acceptance with the word on cpu_rdata and cpu_stall = 0, and issues no bus transaction.
- R3: A write hit on a Modified line updates the selected word with no bus transaction and cpu_stall = 0.
- R4: A write hit on a Shared line issues one invalidate (bus_cmd 2) for the block. On acknowledge the line becomes Modified holding the new word, and cpu_stall = N_INV.
- R5: A read miss issues a shared read (bus_cmd 0) and installs the returned block as Shared. cpu_stall is N_CACHE when bus_c2c was 1 at the acknowledge and N_MEM otherwise, and cpu_rdata is the selected word of the fill.
- R6: A write miss issues an exclusive read (bus_cmd 1), merges the new word into the fetched block and installs the line as Modified, with the same fill cost as R5.
- R7: A miss whose victim line is Modified first issues a writeback (bus_cmd 3) carrying the victim's own block address and data, and only then the fill. cpu_stall then adds N_WB to the fill cost.
- R8: A snooped shared read (snp_cmd 0) that matches a Modified line raises snp_flush in the same cycle, with the line's data on snp_fdata and snp_stall = N_WB, and the line becomes Shared.
- R9: A snooped exclusive read (1) or invalidate (2) that matches a valid line makes it Invalid, raising snp_flush with its data only if it was Modified. Snoops that match no line, and shared reads on a Shared line, change nothing and leave snp_flush at 0.
- R10: bus_req, bus_cmd and bus_blk stay stable until bus_ack. cpu_done is a single-cycle pulse. A CPU request is not accepted in a cycle when snp_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write word |
| cpu_busy | output | 1 | Request in progress |
| cpu_done | output | 1 | Completion pulse |
| cpu_rdata | output | DW | Read word, valid with cpu_done |
| cpu_stall | output | CW | Stall cycles of the access, valid with cpu_done |
| bus_req | output | 1 | Own transaction pending |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 invalidate, 3 writeback |
| bus_blk | output | AW-1 | Block address of the transaction |
| bus_wdata | output | 2*DW | Writeback block |
| bus_ack | input | 1 | Transaction complete, fill data valid |
| bus_rdata | input | 2*DW | Fill block |
| bus_c2c | input | 1 | Fill was supplied by another cache |
| snp_valid | input | 1 | Foreign transaction present |
| snp_cmd | input | 2 | 0 read, 1 read-exclusive, 2 invalidate |
| snp_blk | input | AW-1 | Foreign block address |
| snp_flush | output | 1 | This cache supplies and writes back the block |
| snp_fdata | output | 2*DW | Supplied block |
| snp_stall | output | CW | Writeback stall charged to this cache |

## Verification
A wrong coherence state becomes visible at the ports on the next access to that line. A line wrongly left valid turns an expected miss into a hit, so the bus sequence goes missing and cpu_stall drops to zero at the completion pulse. A line wrongly left Modified shows up as a stray writeback or flush. A wrong tag or wrong data shows up as a bad cpu_rdata on the next read hit, or as a bad block address or payload in a later writeback or snoop flush. The bench therefore mixes random accesses and snoops over sixteen aliasing blocks. It compares every bus command, every block address, every payload and every stall count against a reference copy of the four lines.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } coh_e;

    typedef enum logic [1:0] {
        CMD_RD  = 2'd0,
        CMD_RDX = 2'd1,
        CMD_INV = 2'd2,
        CMD_WB  = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        C_IDLE,
        C_WB,
        C_FETCH,
        C_UPG,
        C_DONE
    } ctl_e;

    localparam int LINE_WORDS = 2;

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int TAGW   = 11,
    parameter int LW     = 16,
    localparam int IDXW  = $clog2(NLINES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IDXW-1:0] cpu_idx,
    input  logic [IDXW-1:0] snp_idx,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  coh_e            wr_st,
    input  logic [TAGW-1:0] wr_tag,
    input  logic [LW-1:0]   wr_data,
    output coh_e            cpu_st,
    output logic [TAGW-1:0] cpu_tag,
    output logic [LW-1:0]   cpu_data,
    output coh_e            snp_st,
    output logic [TAGW-1:0] snp_tag,
    output logic [LW-1:0]   snp_data
);

    coh_e            st_q   [NLINES];
    logic [TAGW-1:0] tag_q  [NLINES];
    logic [LW-1:0]   data_q [NLINES];

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g]   <= ST_I;
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else if (wr_en && wr_idx == IDXW'(g)) begin
                st_q[g]   <= wr_st;
                tag_q[g]  <= wr_tag;
                data_q[g] <= wr_data;
            end
        end
    end

    assign cpu_st   = st_q[cpu_idx];
    assign cpu_tag  = tag_q[cpu_idx];
    assign cpu_data = data_q[cpu_idx];
    assign snp_st   = st_q[snp_idx];
    assign snp_tag  = tag_q[snp_idx];
    assign snp_data = data_q[snp_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAGW = 11,
    parameter int LW   = 16,
    parameter int CW   = 16,
    parameter int N_WB = 10
) (
    input  logic            snp_valid,
    input  bus_cmd_e        snp_cmd,
    input  logic [TAGW-1:0] snp_blk,
    input  coh_e            line_st,
    input  logic [TAGW-1:0] line_tag,
    input  logic [LW-1:0]   line_data,
    output logic            upd,
    output coh_e            upd_st,
    output logic            flush,
    output logic [LW-1:0]   fdata,
    output logic [CW-1:0]   stall
);

    logic match;
    logic dirty;
    logic kill;

    assign match = snp_valid && line_st != ST_I && line_tag == snp_blk;
    assign dirty = match && line_st == ST_M;
    assign kill  = match && (snp_cmd == CMD_RDX || snp_cmd == CMD_INV);

    always_comb begin
        upd    = 1'b0;
        upd_st = line_st;
        flush  = 1'b0;
        if (kill) begin
            upd    = 1'b1;
            upd_st = ST_I;
            flush  = dirty;
        end else if (dirty && snp_cmd == CMD_RD) begin
            upd    = 1'b1;
            upd_st = ST_S;
            flush  = 1'b1;
        end
    end

    assign fdata = flush ? line_data : '0;
    assign stall = flush ? CW'(N_WB) : '0;

endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
    import msi_pkg::*;
#(
    parameter int AW      = 12,
    parameter int DW      = 8,
    parameter int NLINES  = 4,
    parameter int CW      = 16,
    parameter int N_MEM   = 100,
    parameter int N_CACHE = 70,
    parameter int N_INV   = 15,
    parameter int N_WB    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic [DW-1:0]     cpu_rdata,
    output logic [CW-1:0]     cpu_stall,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [AW-2:0]     bus_blk,
    output logic [2*DW-1:0]   bus_wdata,
    input  logic              bus_ack,
    input  logic [2*DW-1:0]   bus_rdata,
    input  logic              bus_c2c,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [AW-2:0]     snp_blk,
    output logic              snp_flush,
    output logic [2*DW-1:0]   snp_fdata,
    output logic [CW-1:0]     snp_stall
);

    localparam int IDXW = $clog2(NLINES);
    localparam int TAGW = AW - 1;
    localparam int LW   = LINE_WORDS * DW;

    function automatic logic [LW-1:0] put_word(logic [LW-1:0] blk, logic sel, logic [DW-1:0] v);
        logic [LW-1:0] r;
        r = blk;
        if (sel) r[LW-1:DW] = v;
        else     r[DW-1:0]  = v;
        return r;
    endfunction

    function automatic logic [DW-1:0] get_word(logic [LW-1:0] blk, logic sel);
        return sel ? blk[LW-1:DW] : blk[DW-1:0];
    endfunction

    ctl_e            ctl_q;
    logic            req_we_q;
    logic [AW-1:0]   req_addr_q;
    logic [DW-1:0]   req_wdata_q;
    logic [DW-1:0]   rdata_q;
    logic [CW-1:0]   stall_q;

    logic [AW-1:0]   lk_addr;
    logic [TAGW-1:0] lk_tag;
    logic            lk_w;
    logic            lk_we;
    logic [DW-1:0]   lk_wdata;
    logic            accept;
    logic            hit;

    coh_e            cpu_st, snp_st, upd_st, cw_st, wr_st;
    logic [TAGW-1:0] cpu_tag, snp_tag, cw_tag, wr_tag;
    logic [LW-1:0]   cpu_data, snp_data, cw_data, wr_data;
    logic            cw_en, upd, wr_en;
    logic [IDXW-1:0] wr_idx;
    bus_cmd_e        bcmd;

    assign lk_addr  = (ctl_q == C_IDLE) ? cpu_addr : req_addr_q;
    assign lk_tag   = lk_addr[AW-1:1];
    assign lk_w     = lk_addr[0];
    assign lk_we    = (ctl_q == C_IDLE) ? cpu_we : req_we_q;
    assign lk_wdata = (ctl_q == C_IDLE) ? cpu_wdata : req_wdata_q;
    assign accept   = ctl_q == C_IDLE && cpu_req && !snp_valid;
    assign hit      = cpu_st != ST_I && cpu_tag == lk_tag;

    msi_line_store #(.NLINES(NLINES), .TAGW(TAGW), .LW(LW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .cpu_idx (lk_addr[IDXW:1]),
        .snp_idx (snp_blk[IDXW-1:0]),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_st   (wr_st),
        .wr_tag  (wr_tag),
        .wr_data (wr_data),
        .cpu_st  (cpu_st),
        .cpu_tag (cpu_tag),
        .cpu_data(cpu_data),
        .snp_st  (snp_st),
        .snp_tag (snp_tag),
        .snp_data(snp_data)
    );

    msi_snoop_unit #(.TAGW(TAGW), .LW(LW), .CW(CW), .N_WB(N_WB)) u_snoop (
        .snp_valid(snp_valid),
        .snp_cmd  (bus_cmd_e'(snp_cmd)),
        .snp_blk  (snp_blk),
        .line_st  (snp_st),
        .line_tag (snp_tag),
        .line_data(snp_data),
        .upd      (upd),
        .upd_st   (upd_st),
        .flush    (snp_flush),
        .fdata    (snp_fdata),
        .stall    (snp_stall)
    );

    // Processor-side line update: write hit on Modified, fill, or upgrade.
    always_comb begin
        cw_en   = 1'b0;
        cw_st   = ST_M;
        cw_tag  = lk_tag;
        cw_data = cpu_data;
        if (accept && hit && cpu_we && cpu_st == ST_M) begin
            cw_en   = 1'b1;
            cw_data = put_word(cpu_data, lk_w, lk_wdata);
        end else if (ctl_q == C_FETCH && bus_ack) begin
            cw_en   = 1'b1;
            cw_st   = lk_we ? ST_M : ST_S;
            cw_data = lk_we ? put_word(bus_rdata, lk_w, lk_wdata) : bus_rdata;
        end else if (ctl_q == C_UPG && bus_ack) begin
            cw_en   = 1'b1;
            cw_data = put_word(cpu_data, lk_w, lk_wdata);
        end
    end

    // Snoop updates win the single write port; the bus never acks and snoops together.
    assign wr_en   = upd || cw_en;
    assign wr_idx  = upd ? snp_blk[IDXW-1:0] : lk_addr[IDXW:1];
    assign wr_st   = upd ? upd_st : cw_st;
    assign wr_tag  = upd ? snp_tag : cw_tag;
    assign wr_data = upd ? snp_data : cw_data;

    always_comb begin
        unique case (ctl_q)
            C_WB:    bcmd = CMD_WB;
            C_FETCH: bcmd = lk_we ? CMD_RDX : CMD_RD;
            C_UPG:   bcmd = CMD_INV;
            default: bcmd = CMD_RD;
        endcase
    end

    assign bus_req   = ctl_q == C_WB || ctl_q == C_FETCH || ctl_q == C_UPG;
    assign bus_cmd   = bcmd;
    assign bus_blk   = (ctl_q == C_WB) ? cpu_tag : lk_tag;
    assign bus_wdata = (ctl_q == C_WB) ? cpu_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q       <= C_IDLE;
            req_we_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            rdata_q     <= '0;
            stall_q     <= '0;
        end else begin
            unique case (ctl_q)
                C_IDLE: if (accept) begin
                    req_we_q    <= cpu_we;
                    req_addr_q  <= cpu_addr;
                    req_wdata_q <= cpu_wdata;
                    if (hit && !cpu_we) begin
                        rdata_q <= get_word(cpu_data, lk_w);
                        stall_q <= '0;
                        ctl_q   <= C_DONE;
                    end else if (hit && cpu_st == ST_M) begin
                        rdata_q <= cpu_wdata;
                        stall_q <= '0;
                        ctl_q   <= C_DONE;
                    end else if (hit) begin
                        stall_q <= CW'(N_INV);
                        ctl_q   <= C_UPG;
                    end else if (cpu_st == ST_M) begin
                        stall_q <= CW'(N_WB);
                        ctl_q   <= C_WB;
                    end else begin
                        stall_q <= '0;
                        ctl_q   <= C_FETCH;
                    end
                end
                C_WB: if (bus_ack) ctl_q <= C_FETCH;
                C_FETCH: if (bus_ack) begin
                    stall_q <= stall_q + (bus_c2c ? CW'(N_CACHE) : CW'(N_MEM));
                    rdata_q <= req_we_q ? req_wdata_q : get_word(bus_rdata, lk_w);
                    ctl_q   <= C_DONE;
                end
                C_UPG: if (bus_ack) begin
                    rdata_q <= req_wdata_q;
                    ctl_q   <= C_DONE;
                end
                default: ctl_q <= C_IDLE;
            endcase
        end
    end

    assign cpu_busy  = ctl_q != C_IDLE;
    assign cpu_done  = ctl_q == C_DONE;
    assign cpu_rdata = rdata_q;
    assign cpu_stall = stall_q;

    assert_bus_hold_R10: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_cmd) && $stable(bus_blk));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    assert_snoop_blocks_accept_R10: assert property (@(posedge clk) disable iff (rst)
        (!cpu_busy && cpu_req && snp_valid) |=> !cpu_busy);

    assert_read_hit_free_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && hit && !cpu_we) |=> cpu_done && cpu_stall == '0);

    assert_wb_then_fill_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_cmd == 2'd3 && bus_ack) |=> bus_req && bus_cmd != 2'd3);

    assert_flush_cost_R8: assert property (@(posedge clk) disable iff (rst)
        snp_flush |-> snp_valid && snp_stall == CW'(N_WB));

endmodule

// File: tb/sim_msi_cache_ctrl.sv
module sim_msi_cache_ctrl;

    localparam int AW = 12, DW = 8, CW = 16;
    localparam int N_MEM = 100, N_CACHE = 70, N_INV = 15, N_WB = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic cpu_req = 0, cpu_we = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_busy, cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic [CW-1:0] cpu_stall;
    logic bus_req;
    logic [1:0] bus_cmd;
    logic [AW-2:0] bus_blk;
    logic [2*DW-1:0] bus_wdata;
    logic bus_ack = 0, bus_c2c = 0;
    logic [2*DW-1:0] bus_rdata = '0;
    logic snp_valid = 0;
    logic [1:0] snp_cmd = '0;
    logic [AW-2:0] snp_blk = '0;
    logic snp_flush;
    logic [2*DW-1:0] snp_fdata;
    logic [CW-1:0] snp_stall;

    always #4 clk = ~clk;

    msi_cache_ctrl #(.AW(AW), .DW(DW), .NLINES(4), .CW(CW), .N_MEM(N_MEM),
        .N_CACHE(N_CACHE), .N_INV(N_INV), .N_WB(N_WB)) u0 (.*);

    int nchk = 0, nerr = 0;
    int r_st [4];               // 0 I, 1 S, 2 M
    logic [AW-2:0] r_tag [4];
    logic [2*DW-1:0] r_data [4];
    logic [2*DW-1:0] mem [2048];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] wsel(logic [2*DW-1:0] b, logic s);
        return s ? b[2*DW-1:DW] : b[DW-1:0];
    endfunction

    task automatic cpu_op(bit we, logic [AW-2:0] blk, bit w, logic [DW-1:0] wd, bit c2c,
                          logic [2*DW-1:0] cdata);
        int idx = int'(blk[1:0]);
        bit hit = r_st[idx] != 0 && r_tag[idx] == blk;
        int exp_cmd [2];
        int ncmd = 0;
        int k = 0;
        int est;
        bit ok_done = 0;
        logic [2*DW-1:0] fill = c2c ? cdata : mem[blk];
        string rq;
        if (!hit) begin
            if (r_st[idx] == 2) begin exp_cmd[ncmd] = 3; ncmd++; end
            exp_cmd[ncmd] = we ? 1 : 0; ncmd++;
            est = (r_st[idx] == 2 ? N_WB : 0) + (c2c ? N_CACHE : N_MEM);
            rq = (r_st[idx] == 2) ? "R7" : (we ? "R6" : "R5");
        end else if (we && r_st[idx] == 1) begin
            exp_cmd[0] = 2; ncmd = 1; est = N_INV; rq = "R4";
        end else begin
            est = 0; rq = we ? "R3" : "R2";
        end
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = {blk, w}; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 0;
        for (int g = 0; g < 40; g++) begin
            if (cpu_done) begin ok_done = 1; break; end
            if (bus_req) begin
                chk(k < ncmd && int'(bus_cmd) == exp_cmd[k], rq, "bus_cmd", int'(bus_cmd),
                    k < ncmd ? exp_cmd[k] : -1);
                if (bus_cmd == 2'd3) begin
                    chk(bus_blk == r_tag[idx], "R7", "wb block", int'(bus_blk), int'(r_tag[idx]));
                    chk(bus_wdata == r_data[idx], "R7", "wb data", int'(bus_wdata), int'(r_data[idx]));
                    mem[bus_blk] = bus_wdata;
                end else begin
                    chk(bus_blk == blk, rq, "bus block", int'(bus_blk), int'(blk));
                end
                bus_rdata = fill; bus_c2c = c2c; bus_ack = 1;
                k++;
            end
            @(negedge clk);
            bus_ack = 0;
        end
        chk(ok_done, rq, "completion", int'(ok_done), 1);
        chk(k == ncmd, rq, "bus transaction count", k, ncmd);
        chk(cpu_stall == CW'(est), rq, "stall", int'(cpu_stall), est);
        if (!we) begin
            logic [DW-1:0] ev = hit ? wsel(r_data[idx], w) : wsel(fill, w);
            chk(cpu_rdata == ev, rq, "read data", int'(cpu_rdata), int'(ev));
        end
        if (!hit) begin
            r_tag[idx] = blk; r_data[idx] = fill; r_st[idx] = we ? 2 : 1;
        end
        if (we) begin
            if (w) r_data[idx][2*DW-1:DW] = wd; else r_data[idx][DW-1:0] = wd;
            r_st[idx] = 2;
        end
    endtask

    task automatic snoop_op(int cmd, logic [AW-2:0] blk);
        int idx = int'(blk[1:0]);
        bit match = r_st[idx] != 0 && r_tag[idx] == blk;
        bit ef = match && r_st[idx] == 2;
        string rq = (cmd == 0) ? "R8" : "R9";
        if (!match || (cmd == 0 && r_st[idx] == 1)) rq = "R9";
        @(negedge clk);
        snp_valid = 1; snp_cmd = 2'(cmd); snp_blk = blk;
        #1;
        chk(snp_flush == ef, rq, "snp_flush", int'(snp_flush), int'(ef));
        if (ef) begin
            chk(snp_fdata == r_data[idx], rq, "snp_fdata", int'(snp_fdata), int'(r_data[idx]));
            chk(snp_stall == CW'(N_WB), rq, "snp_stall", int'(snp_stall), N_WB);
            mem[blk] = r_data[idx];
        end
        @(negedge clk);
        snp_valid = 0;
        if (match && cmd != 0) r_st[idx] = 0;
        else if (ef && cmd == 0) r_st[idx] = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1d5a);
        for (int i = 0; i < 2048; i++) mem[i] = 16'((i * 16'h0131) ^ 16'h5a3c);
        for (int i = 0; i < 4; i++) begin r_st[i] = 0; r_tag[i] = '0; r_data[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(!cpu_busy && !cpu_done && !bus_req && !snp_flush, "R1", "idle outputs",
            {cpu_busy, cpu_done, bus_req, snp_flush}, 0);
        // R1: block 0 (tag 0, matching reset tag) must still miss
        cpu_op(0, 11'd0, 0, 8'h00, 0, '0);
        // directed corner cases
        cpu_op(0, 11'd0, 1, 8'h00, 0, '0);          // R2 read hit
        cpu_op(1, 11'd0, 1, 8'hA5, 0, '0);          // R4 upgrade
        cpu_op(1, 11'd0, 0, 8'h3C, 0, '0);          // R3 write hit M
        snoop_op(0, 11'd0);                          // R8 flush, to S
        snoop_op(0, 11'd0);                          // R9 read on S: no effect
        cpu_op(1, 11'd5, 0, 8'h77, 1, 16'hBEEF);    // R6 write miss, cache-filled
        cpu_op(0, 11'd9, 1, 8'h00, 0, '0);          // R7 evict Modified
        snoop_op(2, 11'd9);                          // R9 invalidate S
        snoop_op(1, 11'd13);                         // R9 no match
        cpu_op(1, 11'd2, 1, 8'h11, 0, '0);
        snoop_op(1, 11'd2);                          // R9 RDX on M: flush, to I
        // R10: request coinciding with a snoop is not accepted
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = {11'd2, 1'b0};
        snp_valid = 1; snp_cmd = 2'd2; snp_blk = 11'd7;
        @(negedge clk);
        cpu_req = 0; snp_valid = 0;
        chk(!cpu_busy && !bus_req, "R10", "accept during snoop", {cpu_busy, bus_req}, 0);
        // random mix
        for (int n = 0; n < 600; n++) begin
            int kind = int'($urandom % 8);
            logic [AW-2:0] b = 11'($urandom % 16);
            if (kind < 2) snoop_op(int'($urandom % 3), b);
            else cpu_op(kind >= 5, b, 1'($urandom), 8'($urandom), 1'($urandom),
                        16'($urandom));
        end
        repeat (3) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule